// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block pairs two eight-line interrupt controllers into one sixteen-input controller. External inputs 0 to 7 feed the primary controller and inputs 8 to 15 feed the secondary one, with the low three bits of the input number used as the line number. Whenever the secondary controller has a request that wins its own arbitration, that request is forwarded as a pending request on line 2 of the primary controller. The processor sees a single request output that follows the primary controller's arbitration.

The processor answers with a one-cycle acknowledge strobe. On the next cycle an 8-bit vector is presented. It is formed from the programmed base of the controller that finally served the request and the winning line number. Both levels fall back to line 7 when nothing wins. A small byte-wide port map reaches each controller's command and data ports and their trigger-mode registers. Each trigger-mode register has a fixed write mask, so that some lines always stay edge-triggered.

Top module: `cascPair`

## Requirements
- R1: Raising external input n (0..7, n not 2) in edge mode makes `intReq` high. An acknowledge then returns vector {primary base[7:3], n}.
- R2: Raising external input 8+n makes `intReq` high through primary line 2. An acknowledge returns {secondary base[7:3], n}, and sets in-service bit 2 of the primary and bit n of the secondary.
- R3: `intReq` is high exactly when the primary has an unmasked pending line of higher priority than every in-service line. A line masked through the data port (bit n = 1 masks line n) cannot raise it.
- R4: An acknowledge while the primary has no winner returns {primary base, 3'd7} and sets no in-service bit.
- R5: When the primary's winner is line 2 but the secondary has no winner, the vector is {secondary base, 3'd7}. Only primary in-service bit 2 is set.
- R6: A trigger-mode write stores the data ANDed with 8'hF8 for the primary and 8'hDE for the secondary. A 1 bit means level mode.
- R7: A level-mode line keeps its pending bit after acknowledge and loses it when the input drops. An edge-mode line loses its pending bit on acknowledge.
- R8: The port map is 16'h0020/16'h0021 for primary command/data, 16'h00A0/16'h00A1 for secondary command/data, and 16'h04D0/16'h04D1 for primary/secondary trigger mode. Address bit 7 selects the controller for the first four ports. Writes to any other address are ignored, and reads from any other address return 0.
- R9: A command write with bits 3 and 2 set arms a poll. The next command-port read of that controller returns its winning line, or 7 if none, and clears that line's pending and in-service bits. A poll on the secondary also clears primary pending and in-service bit 2.
- R10: Lower line numbers win, and an in-service line blocks itself and lower-priority lines. A command with bits 7:5 = 001 clears the highest-priority in-service bit. A command with bits 7:5 = 011 clears in-service bit [2:0].
- R11: A command write with bit 4 set clears the mask, pending and in-service bits. The next data write loads the vector base from bits 7:3.
- R12: `vecOut` changes only in the cycle after `intAck`. `intReq` reflects the post-acknowledge state from that same cycle.
- R13: A command write with bits 3 and 1 set selects the command-port read: bit 0 = 1 returns in-service bits, and 0 returns pending bits. The data port reads back the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 16 | External interrupt inputs |
| addr | input | 16 | Port address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, valid while rdEn is high |
| intAck | input | 1 | One-cycle acknowledge strobe |
| intReq | output | 1 | Processor interrupt request |
| vecOut | output | 8 | Vector, loaded the cycle after intAck |

## Verification
The hardest state to reach is a spurious request at the secondary level. Primary line 2 must be pending while the secondary has no winner. The stimulus reaches it by raising a secondary input, waiting the two cycles the cascade needs to latch primary line 2, and then masking that input at the secondary before acknowledging. Randomly chosen pairs of inputs across both controllers then exercise the order in which vectors are returned. Directed sequences cover polling, level triggering and re-initialisation.

// File: rtl/cascPairPkg.sv
package cascPairPkg;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int BYTE_W = 8;
  localparam int BASE_W = BYTE_W - LINE_W;
  localparam int ADDR_W = 16;
  localparam int UNITS  = 2;

  localparam logic [ADDR_W-1:0] ADR_LOW_BASE = 16'h0020;
  localparam logic [ADDR_W-1:0] ADR_LOW_DONT = 16'h0081;
  localparam logic [ADDR_W-1:0] ADR_M_TRIG   = 16'h04D0;
  localparam logic [ADDR_W-1:0] ADR_S_TRIG   = 16'h04D1;

  localparam logic [BYTE_W-1:0] M_TRIG_MASK = 8'hF8;
  localparam logic [BYTE_W-1:0] S_TRIG_MASK = 8'hDE;

  localparam int CASC_LINE = 2;
  localparam logic [LINE_W-1:0] SPUR_LINE = LINE_W'(LINES - 1);

  typedef enum logic [2:0] {
    RD_NONE, RD_M_CMD, RD_M_DAT, RD_S_CMD, RD_S_DAT, RD_M_TRIG, RD_S_TRIG
  } rdSel_e;

  typedef struct packed {
    logic              wrCmd;
    logic              wrData;
    logic              wrTrig;
    logic              pollRd;
    logic              ack;
    logic [LINE_W-1:0] ackLine;
    logic              cascSet;
    logic              clrCasc;
  } unitStrobe_t;

  typedef struct packed {
    unitStrobe_t [UNITS-1:0] unit;
    logic              vecLoad;
    logic              vecFromSlave;
    logic [LINE_W-1:0] vecLine;
    rdSel_e            rdSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              winValid;
    logic [LINE_W-1:0] winLine;
    logic              pollOn;
  } unitStatus_t;
endpackage

// File: rtl/cascUnit.sv
module cascUnit
  import cascPairPkg::*;
#(
  parameter logic [BYTE_W-1:0] TRIG_MASK = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineIn,
  input  logic [BYTE_W-1:0] wrVal,
  input  unitStrobe_t       stb,
  output unitStatus_t       stat,
  output logic [LINES-1:0]  irrQ,
  output logic [LINES-1:0]  isrQ,
  output logic [LINES-1:0]  imrQ,
  output logic [LINES-1:0]  trigQ,
  output logic [BASE_W-1:0] baseQ,
  output logic              readSel
);
  logic [LINES-1:0]  lastQ, irrN, isrN, reqMask;
  logic              reqValid, isrValid, initPend, pollQ;
  logic [LINE_W-1:0] reqLine, isrLine;

  // fixed priority: lowest index wins
  always_comb begin
    reqMask  = irrQ & ~imrQ;
    reqValid = |reqMask;
    isrValid = |isrQ;
    reqLine  = '0;
    isrLine  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (reqMask[i]) reqLine = LINE_W'(i);
      if (isrQ[i])    isrLine = LINE_W'(i);
    end
  end

  assign stat.winValid = reqValid && (!isrValid || reqLine < isrLine);
  assign stat.winLine  = reqLine;
  assign stat.pollOn   = pollQ;

  always_comb begin
    irrN = irrQ;
    isrN = isrQ;
    for (int i = 0; i < LINES; i++) begin
      if (trigQ[i])                    irrN[i] = lineIn[i];
      else if (lineIn[i] && !lastQ[i]) irrN[i] = 1'b1;
    end
    if (stb.cascSet) irrN[CASC_LINE] = 1'b1;
    if (stb.ack) begin
      isrN[stb.ackLine] = 1'b1;
      if (!trigQ[stb.ackLine]) irrN[stb.ackLine] = 1'b0;
    end
    if (stb.pollRd && stat.winValid) begin
      irrN[stat.winLine] = 1'b0;
      isrN[stat.winLine] = 1'b0;
    end
    if (stb.clrCasc) begin
      irrN[CASC_LINE] = 1'b0;
      isrN[CASC_LINE] = 1'b0;
    end
    if (stb.wrCmd) begin
      if (wrVal[4]) begin
        irrN = '0;
        isrN = '0;
      end else if (!wrVal[3]) begin
        case (wrVal[7:5])
          3'b001:  if (isrValid) isrN[isrLine] = 1'b0;
          3'b011:  isrN[wrVal[LINE_W-1:0]] = 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastQ    <= '0;
      irrQ     <= '0;
      isrQ     <= '0;
      imrQ     <= '0;
      trigQ    <= '0;
      baseQ    <= '0;
      readSel  <= 1'b0;
      initPend <= 1'b0;
      pollQ    <= 1'b0;
    end else begin
      lastQ <= lineIn;
      irrQ  <= irrN;
      isrQ  <= isrN;
      if (stb.pollRd) pollQ <= 1'b0;
      if (stb.wrCmd) begin
        if (wrVal[4]) begin
          imrQ     <= '0;
          initPend <= 1'b1;
          readSel  <= 1'b0;
          pollQ    <= 1'b0;
        end else if (wrVal[3]) begin
          if (wrVal[2]) pollQ   <= 1'b1;
          if (wrVal[1]) readSel <= wrVal[0];
        end
      end
      if (stb.wrData) begin
        if (initPend) begin
          baseQ    <= wrVal[BYTE_W-1:LINE_W];
          initPend <= 1'b0;
        end else begin
          imrQ <= wrVal;
        end
      end
      if (stb.wrTrig) trigQ <= wrVal & TRIG_MASK;
    end
  end
endmodule

// File: rtl/cascDatapath.sv
module cascDatapath
  import cascPairPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [UNITS*LINES-1:0]    irqLines,
  input  logic [BYTE_W-1:0]         wrData,
  input  ctrlStrobe_t               stb,
  output unitStatus_t [UNITS-1:0]   stat,
  output logic [BYTE_W-1:0]         rdData,
  output logic [BYTE_W-1:0]         vecOut
);
  logic [UNITS-1:0][LINES-1:0]  irr, isr, imr, trig;
  logic [UNITS-1:0][BASE_W-1:0] base;
  logic [UNITS-1:0]             readSel;
  logic [UNITS-1:0][BYTE_W-1:0] cmdView;

  for (genvar u = 0; u < UNITS; u++) begin : gUnit
    localparam logic [BYTE_W-1:0] MASK = (u == 0) ? M_TRIG_MASK : S_TRIG_MASK;
    cascUnit #(.TRIG_MASK(MASK)) unit (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (irqLines[u*LINES +: LINES]),
      .wrVal   (wrData),
      .stb     (stb.unit[u]),
      .stat    (stat[u]),
      .irrQ    (irr[u]),
      .isrQ    (isr[u]),
      .imrQ    (imr[u]),
      .trigQ   (trig[u]),
      .baseQ   (base[u]),
      .readSel (readSel[u])
    );
    always_comb begin
      if (stat[u].pollOn)
        cmdView[u] = {{BASE_W{1'b0}}, stat[u].winValid ? stat[u].winLine : SPUR_LINE};
      else
        cmdView[u] = readSel[u] ? isr[u] : irr[u];
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_M_CMD:  rdData = cmdView[0];
      RD_M_DAT:  rdData = imr[0];
      RD_S_CMD:  rdData = cmdView[1];
      RD_S_DAT:  rdData = imr[1];
      RD_M_TRIG: rdData = trig[0];
      RD_S_TRIG: rdData = trig[1];
      default:   rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecOut <= '0;
    else if (stb.vecLoad)
      vecOut <= {base[stb.vecFromSlave ? 1 : 0], stb.vecLine};
  end
endmodule

// File: rtl/cascControl.sv
module cascControl
  import cascPairPkg::*;
(
  input  logic                    intAck,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       addr,
  input  unitStatus_t [UNITS-1:0] stat,
  output ctrlStrobe_t             stb
);
  logic lowHit, unitSel, isData, mTrigHit, sTrigHit, slavePoll;

  assign lowHit   = (addr & ~ADR_LOW_DONT) == ADR_LOW_BASE;
  assign unitSel  = addr[7];
  assign isData   = addr[0];
  assign mTrigHit = addr == ADR_M_TRIG;
  assign sTrigHit = addr == ADR_S_TRIG;
  assign slavePoll = rdEn && lowHit && unitSel && !isData && stat[1].pollOn;

  always_comb begin
    stb = '0;
    for (int u = 0; u < UNITS; u++) begin
      stb.unit[u].wrCmd  = wrEn && lowHit && (unitSel == u[0]) && !isData;
      stb.unit[u].wrData = wrEn && lowHit && (unitSel == u[0]) && isData;
      stb.unit[u].pollRd = rdEn && lowHit && (unitSel == u[0]) && !isData && stat[u].pollOn;
    end
    stb.unit[0].wrTrig  = wrEn && mTrigHit;
    stb.unit[1].wrTrig  = wrEn && sTrigHit;
    stb.unit[0].cascSet = stat[1].winValid && !intAck;
    stb.unit[0].clrCasc = slavePoll && stat[1].winValid;

    if (!rdEn)              stb.rdSel = RD_NONE;
    else if (lowHit)        stb.rdSel = unitSel ? (isData ? RD_S_DAT : RD_S_CMD)
                                                : (isData ? RD_M_DAT : RD_M_CMD);
    else if (mTrigHit)      stb.rdSel = RD_M_TRIG;
    else if (sTrigHit)      stb.rdSel = RD_S_TRIG;
    else                    stb.rdSel = RD_NONE;

    stb.vecLoad = intAck;
    stb.vecLine = SPUR_LINE;
    if (intAck && stat[0].winValid) begin
      stb.unit[0].ack     = 1'b1;
      stb.unit[0].ackLine = stat[0].winLine;
      if (stat[0].winLine == LINE_W'(CASC_LINE)) begin
        stb.vecFromSlave = 1'b1;
        if (stat[1].winValid) begin
          stb.unit[1].ack     = 1'b1;
          stb.unit[1].ackLine = stat[1].winLine;
          stb.vecLine         = stat[1].winLine;
        end
      end else begin
        stb.vecLine = stat[0].winLine;
      end
    end
  end
endmodule

// File: rtl/cascPair.sv
module cascPair
  import cascPairPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [UNITS*LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [BYTE_W-1:0]      wrData,
  input  logic                   rdEn,
  output logic [BYTE_W-1:0]      rdData,
  input  logic                   intAck,
  output logic                   intReq,
  output logic [BYTE_W-1:0]      vecOut
);
  ctrlStrobe_t             stb;
  unitStatus_t [UNITS-1:0] stat;

  cascControl ctrl (
    .intAck (intAck),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .stat   (stat),
    .stb    (stb)
  );

  cascDatapath path (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .wrData   (wrData),
    .stb      (stb),
    .stat     (stat),
    .rdData   (rdData),
    .vecOut   (vecOut)
  );

  assign intReq = stat[0].winValid;
endmodule

// File: rtl/cascPairChk.sv
module cascPairChk
  import cascPairPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              intAck,
  input logic              intReq,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] rdData,
  input logic [BYTE_W-1:0] vecOut
);
  logic inMap;
  assign inMap = ((addr & ~ADR_LOW_DONT) == ADR_LOW_BASE) ||
                 addr == ADR_M_TRIG || addr == ADR_S_TRIG;

  assert_vec_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> $stable(vecOut));

  assert_spur_master_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq) |=> vecOut[LINE_W-1:0] == SPUR_LINE);

  assert_trig_mask_m_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADR_M_TRIG) |-> (rdData & ~M_TRIG_MASK) == '0);

  assert_trig_mask_s_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADR_S_TRIG) |-> (rdData & ~S_TRIG_MASK) == '0);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !inMap) |-> rdData == '0);

  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
endmodule

bind cascPair cascPairChk chk (
  .clk    (clk),
  .rstN   (rstN),
  .intAck (intAck),
  .intReq (intReq),
  .rdEn   (rdEn),
  .addr   (addr),
  .rdData (rdData),
  .vecOut (vecOut)
);

// File: tb/cascPair_test.sv
module cascPair_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqLines = '0;
  logic [15:0] addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0, intAck = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData, vecOut;
  logic        intReq;
  int          nRun = 0, nFail = 0;
  logic [7:0]  v, r;

  always #10 clk = ~clk;

  cascPair uut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .intAck(intAck),
    .intReq(intReq), .vecOut(vecOut)
  );

  localparam logic [7:0] MBASE = 8'h40, SBASE = 8'h70;

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #5 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ackv(output logic [7:0] vv);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0; vv = vecOut;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eoi(logic [7:0] vv);
    if (vv[7:3] == SBASE[7:3]) wr(16'h00A0, 8'h20);
    wr(16'h0020, 8'h20);
  endtask

  function automatic logic [7:0] expVec(logic [15:0] m);
    logic [7:0] eff;
    eff = m[7:0] | {5'b0, |m[15:8], 2'b0};
    for (int i = 0; i < 8; i++)
      if (eff[i]) begin
        if (i == 2) begin
          for (int j = 0; j < 8; j++) if (m[8+j]) return SBASE | 8'(j);
          return SBASE | 8'd7;
        end
        return MBASE | 8'(i);
      end
    return MBASE | 8'd7;
  endfunction

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3); rstN = 1'b1; idle(1);
    chk("reset intReq", 16'(intReq), 16'h0);
    chk("reset vecOut", 16'(vecOut), 16'h0);
    rd(16'h0021, r); chk("reset mask R13", 16'(r), 16'h0);

    // R11 init and base programming
    wr(16'h0021, 8'hF0); rd(16'h0021, r); chk("R13 mask readback", 16'(r), 16'hF0);
    wr(16'h0020, 8'h10); rd(16'h0021, r); chk("R11 init clears mask", 16'(r), 16'h0);
    wr(16'h0021, 8'h88);
    irqLines[1] = 1'b1; idle(2);
    ackv(v); chk("R11 new base", 16'(v), 16'h89);
    wr(16'h0020, 8'h20); irqLines[1] = 1'b0;
    wr(16'h0020, 8'h10); wr(16'h0021, MBASE);
    wr(16'h00A0, 8'h10); wr(16'h00A1, SBASE);

    // R4 no winner
    ackv(v); chk("R4 spurious primary", 16'(v), 16'h47);
    wr(16'h0020, 8'h0B); rd(16'h0020, r); chk("R4 no in-service", 16'(r), 16'h0);
    wr(16'h0020, 8'h0A);

    // R1 / R12
    irqLines[5] = 1'b1; idle(2);
    chk("R1 request", 16'(intReq), 16'h1);
    ackv(v); chk("R1 vector", 16'(v), 16'h45);
    chk("R12 request dropped after ack", 16'(intReq), 16'h0);
    idle(2); chk("R12 vector held", 16'(vecOut), 16'h45);
    wr(16'h0020, 8'h20); irqLines[5] = 1'b0;

    // R2 cascade
    irqLines[13] = 1'b1; idle(3);
    chk("R2 cascade request", 16'(intReq), 16'h1);
    ackv(v); chk("R2 vector", 16'(v), 16'h75);
    wr(16'h0020, 8'h0B); rd(16'h0020, r); chk("R2 primary isr", 16'(r), 16'h04);
    wr(16'h00A0, 8'h0B); rd(16'h00A0, r); chk("R2 secondary isr", 16'(r), 16'h20);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    wr(16'h0020, 8'h0A); wr(16'h00A0, 8'h0A); irqLines[13] = 1'b0;

    // R5 spurious at secondary level
    irqLines[9] = 1'b1; idle(3);
    wr(16'h00A1, 8'h02);
    chk("R5 primary still requests", 16'(intReq), 16'h1);
    ackv(v); chk("R5 spurious secondary vector", 16'(v), 16'h77);
    wr(16'h0020, 8'h0B); rd(16'h0020, r); chk("R5 primary isr", 16'(r), 16'h04);
    wr(16'h00A0, 8'h0B); rd(16'h00A0, r); chk("R5 secondary isr empty", 16'(r), 16'h0);
    wr(16'h0020, 8'h20); wr(16'h00A1, 8'h00); idle(3);
    ackv(v); chk("R5 request after unmask", 16'(v), 16'h71);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    wr(16'h0020, 8'h0A); wr(16'h00A0, 8'h0A); irqLines[9] = 1'b0;

    // R3 masking
    wr(16'h0021, 8'h01); irqLines[0] = 1'b1; idle(2);
    chk("R3 masked no request", 16'(intReq), 16'h0);
    wr(16'h0021, 8'h00);
    chk("R3 unmask raises request", 16'(intReq), 16'h1);
    ackv(v); chk("R3 vector", 16'(v), 16'h40);
    wr(16'h0020, 8'h20); irqLines[0] = 1'b0;

    // R6 trigger masks
    wr(16'h04D0, 8'hFF); rd(16'h04D0, r); chk("R6 primary mask", 16'(r), 16'hF8);
    wr(16'h04D1, 8'hFF); rd(16'h04D1, r); chk("R6 secondary mask", 16'(r), 16'hDE);
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);

    // R7 level mode
    wr(16'h04D0, 8'h08); irqLines[3] = 1'b1; idle(2);
    ackv(v); chk("R7 level vector", 16'(v), 16'h43);
    rd(16'h0020, r); chk("R7 level stays pending", 16'(r), 16'h08);
    wr(16'h0020, 8'h20); idle(1);
    chk("R7 level re-requests", 16'(intReq), 16'h1);
    ackv(v); chk("R7 second vector", 16'(v), 16'h43);
    wr(16'h0020, 8'h20); irqLines[3] = 1'b0; idle(2);
    rd(16'h0020, r); chk("R7 level clears on drop", 16'(r), 16'h0);
    chk("R7 no request", 16'(intReq), 16'h0);
    wr(16'h04D0, 8'h00);

    // R8 decode
    wr(16'h0121, 8'h55); rd(16'h0021, r); chk("R8 unmapped write ignored", 16'(r), 16'h0);
    rd(16'h0121, r); chk("R8 unmapped read zero", 16'(r), 16'h0);
    rd(16'h0022, r); chk("R8 unmapped read zero b", 16'(r), 16'h0);
    wr(16'h00A1, 8'h3C); rd(16'h00A1, r); chk("R8 bit7 selects secondary", 16'(r), 16'h3C);
    rd(16'h0021, r); chk("R8 primary untouched", 16'(r), 16'h0);
    wr(16'h00A1, 8'h00);

    // R9 poll on secondary
    irqLines[12] = 1'b1; idle(3);
    wr(16'h00A0, 8'h0C); rd(16'h00A0, r); chk("R9 poll line", 16'(r), 16'h04);
    idle(1);
    rd(16'h0020, r); chk("R9 primary line 2 cleared", 16'(r), 16'h0);
    rd(16'h00A0, r); chk("R9 secondary pending cleared", 16'(r), 16'h0);
    chk("R9 no request", 16'(intReq), 16'h0);
    irqLines[12] = 1'b0;

    // R10 priority and EOI forms
    irqLines[4] = 1'b1; idle(2);
    ackv(v); chk("R10 first", 16'(v), 16'h44);
    irqLines[6] = 1'b1; idle(2);
    chk("R10 lower priority blocked", 16'(intReq), 16'h0);
    irqLines[3] = 1'b1; idle(2);
    chk("R10 higher priority preempts", 16'(intReq), 16'h1);
    ackv(v); chk("R10 nested vector", 16'(v), 16'h43);
    wr(16'h0020, 8'h64); wr(16'h0020, 8'h0B);
    rd(16'h0020, r); chk("R10 specific eoi", 16'(r), 16'h08);
    wr(16'h0020, 8'h20); rd(16'h0020, r); chk("R10 nonspecific eoi", 16'(r), 16'h0);
    wr(16'h0020, 8'h0A); idle(1);
    ackv(v); chk("R10 deferred line", 16'(v), 16'h46);
    wr(16'h0020, 8'h20); irqLines = '0; idle(2);

    // random pairs, R1/R2/R10
    for (int k = 0; k < 40; k++) begin
      int a, b;
      logic [15:0] m;
      a = int'($urandom % 16); if (a == 2) a = 3;
      b = int'($urandom % 16); if (b == 2) b = 11;
      m = (16'h1 << a) | (16'h1 << b);
      @(negedge clk); irqLines = m; idle(3);
      chk("R3 random request", 16'(intReq), 16'h1);
      ackv(v); chk("R10 random first vector", 16'(v), 16'(expVec(m)));
      m &= ~(16'h1 << ((v[7:3] == SBASE[7:3]) ? 8 + int'(v[2:0]) : int'(v[2:0])));
      eoi(v);
      if (m != '0) begin
        idle(3);
        ackv(v); chk("R2 random second vector", 16'(v), 16'(expVec(m)));
        eoi(v);
      end
      irqLines = '0; idle(2);
      chk("R3 random idle", 16'(intReq), 16'h0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule